// File: doc/BRIEF.md
# Write-Tracking Masked Context Save and Restore Engine

This block watches the write strobes of a 32-entry register file and keeps one flag per register. A flag is set when its register is written. All flags are cleared when a new execution context begins. When a context is saved, the engine uses that flag vector as the list of registers to save, so software never picks the list or looks at the bits.

A save command takes a base address. The engine first stores the flag vector as a descriptor word at the base. It then stores only the flagged registers, one memory word each, at the following addresses. The frame therefore holds one word plus one word per flagged register. A restore command reads the descriptor back from a base address. It then reads the same number of words and writes each word into the register it came from.

Both sequences wait on memory backpressure. At the end the engine pulses a completion flag and reports the first address past the frame. The instruction decoder, caches, bus fabric and scheduling policy are outside this block.

Top module: `dirty_save_engine`

## Requirements
- R1: A write strobe `rf_we` with index `rf_waddr` sets bit `rf_waddr` of `dirty_mask` on the next clock edge. The flag stays set until a context switch clears it.
- R2: A `ctx_switch` pulse with no write in the same cycle clears every bit of `dirty_mask` to 0 on the next edge.
- R3: When `ctx_switch` and `rf_we` are high in the same cycle, `dirty_mask` becomes exactly the one-hot bit of `rf_waddr`. The write counts toward the new context.
- R4: A save begins with a write beat at the command's base address. Its data is the `dirty_mask` value captured when the command was accepted: bit i stands for register i, and bits above the register count are zero.
- R5: After the descriptor, a save writes the flagged registers in ascending index order to base+4, base+8 and so on. The engine presents each index on `rf_rd_idx` and takes the data from `rf_rd_data`.
- R6: A restore reads the descriptor at the base address. It then reads base+4 onward and asserts `rf_wb_en` with the ascending flagged index and the memory data, once per beat. Registers that are not flagged are never written back.
- R7: One cycle after the last accepted beat, `done` is high for exactly one cycle. At the same time `sp_out` equals base + 4 × (1 + number of flagged registers), for both save and restore.
- R8: `busy` is high from the cycle after an accepted command until the last beat is accepted. Commands that arrive while `busy` is high are ignored. If save and restore commands arrive in the same idle cycle, the save wins.
- R9: A beat is accepted in a cycle where `mem_req` and `mem_ready` are both high. While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` hold their values, and no beat is lost or repeated.
- R10: Read data is taken from `mem_rdata` in the accepting cycle. Each following beat's address is 4 higher than the previous accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_we | input | 1 | Register-file write strobe |
| rf_waddr | input | 5 | Index of the register being written |
| ctx_switch | input | 1 | Context-switch pulse; clears the flags |
| cmd_push | input | 1 | Start a masked save |
| cmd_pop | input | 1 | Start a masked restore |
| cmd_sp | input | 32 | Frame base address for the command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | First address past the frame |
| dirty_mask | output | 32 | Written-since-switch flags |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| rf_rd_idx | output | 5 | Register index read for a save |
| rf_rd_data | input | 32 | Combinational read data for `rf_rd_idx` |
| rf_wb_en | output | 1 | Restore write-back strobe |
| rf_wb_idx | output | 5 | Restore write-back index |
| rf_wb_data | output | 32 | Restore write-back data |

## Verification
The assertions check these on every cycle:
- flag setting on a write, including a write merged with a context switch;
- clearing on a switch without a write;
- address and direction holding during a stall;
- the 4-byte address step between accepted beats;
- write-backs occurring only on accepted read beats;
- `done` never coinciding with `busy`.

Only the bench scenarios can show the rest:
- that the descriptor word and the ascending register order carry the right data;
- that a restore returns exactly the saved registers and leaves the others untouched;
- that the final address matches the popcount;
- that a command issued during a sequence, or save and restore issued together, resolve as required.

// File: rtl/dse_pkg.sv
package dse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SDESC,
      ST_SREG,
      ST_LDESC,
      ST_LREG
   } dse_state_e;
endpackage

// File: rtl/dse_flags.sv
module dse_flags #(
   parameter int NREGS = 32,
   localparam int IDXW = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDXW-1:0]  waddr,
   input  logic             clr,
   output logic [NREGS-1:0] flags
);
   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_bit
         logic hit;
         assign hit = we && (waddr == IDXW'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags[gi] <= 1'b0;
            else if (hit)
               flags[gi] <= 1'b1;   // write wins over a same-cycle clear
            else if (clr)
               flags[gi] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/dse_lowbit.sv
module dse_lowbit #(
   parameter int N  = 32,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (vec[i]) idx = IW'(i);
      any = |vec;
   end
endmodule

// File: rtl/dse_seq.sv
module dse_seq
   import dse_pkg::*;
#(
   parameter int NREGS = 32,
   parameter int DW    = 32,
   parameter int AW    = 32,
   localparam int IDXW  = $clog2(NREGS),
   localparam int BYTES = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_push,
   input  logic             cmd_pop,
   input  logic [AW-1:0]    cmd_sp,
   input  logic [NREGS-1:0] snap_mask,
   output logic [NREGS-1:0] pend,
   input  logic [IDXW-1:0]  pick_idx,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata,
   output logic [IDXW-1:0]  rf_rd_idx,
   input  logic [DW-1:0]    rf_rd_data,
   output logic             rf_wb_en,
   output logic [IDXW-1:0]  rf_wb_idx,
   output logic [DW-1:0]    rf_wb_data,
   output logic             busy,
   output logic             done,
   output logic [AW-1:0]    sp_out
);
   dse_state_e       st_q, st_d;
   logic [AW-1:0]    addr_q, addr_d;
   logic [NREGS-1:0] pend_q, pend_d, pend_clr, desc_in;
   logic             done_d, fin;
   logic [AW-1:0]    sp_q, sp_d;
   logic             accept;

   assign pend       = pend_q;
   assign busy       = (st_q != ST_IDLE);
   assign mem_req    = busy;
   assign mem_we     = (st_q == ST_SDESC) || (st_q == ST_SREG);
   assign mem_addr   = addr_q;
   assign mem_wdata  = (st_q == ST_SDESC) ? DW'(pend_q) : rf_rd_data;
   assign rf_rd_idx  = pick_idx;
   assign accept     = mem_req && mem_ready;
   assign rf_wb_en   = (st_q == ST_LREG) && accept;
   assign rf_wb_idx  = pick_idx;
   assign rf_wb_data = mem_rdata;
   assign done       = fin;
   assign sp_out     = sp_q;
   assign pend_clr   = pend_q & ~(NREGS'(1) << pick_idx);
   assign desc_in    = mem_rdata[NREGS-1:0];

   always_comb begin
      st_d   = st_q;
      addr_d = addr_q;
      pend_d = pend_q;
      done_d = 1'b0;
      sp_d   = sp_q;
      unique case (st_q)
         ST_IDLE: begin
            if (cmd_push) begin
               st_d   = ST_SDESC;
               addr_d = cmd_sp;
               pend_d = snap_mask;
            end else if (cmd_pop) begin
               st_d   = ST_LDESC;
               addr_d = cmd_sp;
               pend_d = '0;
            end
         end
         ST_SDESC: if (accept) begin
            addr_d = addr_q + AW'(BYTES);
            if (pend_q == '0) begin
               st_d = ST_IDLE; done_d = 1'b1; sp_d = addr_d;
            end else
               st_d = ST_SREG;
         end
         ST_LDESC: if (accept) begin
            addr_d = addr_q + AW'(BYTES);
            pend_d = desc_in;
            if (desc_in == '0) begin
               st_d = ST_IDLE; done_d = 1'b1; sp_d = addr_d;
            end else
               st_d = ST_LREG;
         end
         ST_SREG, ST_LREG: if (accept) begin
            addr_d = addr_q + AW'(BYTES);
            pend_d = pend_clr;
            if (pend_clr == '0) begin
               st_d = ST_IDLE; done_d = 1'b1; sp_d = addr_d;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         pend_q <= '0;
         fin    <= 1'b0;
         sp_q   <= '0;
      end else begin
         st_q   <= st_d;
         addr_q <= addr_d;
         pend_q <= pend_d;
         fin    <= done_d;
         sp_q   <= sp_d;
      end
   end
endmodule

// File: rtl/dirty_save_engine.sv
module dirty_save_engine #(
   parameter int NREGS = 32,
   parameter int DW    = 32,
   parameter int AW    = 32,
   localparam int IDXW = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rf_we,
   input  logic [IDXW-1:0]  rf_waddr,
   input  logic             ctx_switch,
   input  logic             cmd_push,
   input  logic             cmd_pop,
   input  logic [AW-1:0]    cmd_sp,
   output logic             busy,
   output logic             done,
   output logic [AW-1:0]    sp_out,
   output logic [NREGS-1:0] dirty_mask,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata,
   output logic [IDXW-1:0]  rf_rd_idx,
   input  logic [DW-1:0]    rf_rd_data,
   output logic             rf_wb_en,
   output logic [IDXW-1:0]  rf_wb_idx,
   output logic [DW-1:0]    rf_wb_data
);
   generate
      if (NREGS > DW) begin : g_bad_desc
         $error("descriptor word narrower than register count");
      end
      if (NREGS < 2) begin : g_bad_regs
         $error("register count must be at least 2");
      end
      if ((DW % 8) != 0) begin : g_bad_dw
         $error("data width must be whole bytes");
      end
   endgenerate

   logic [NREGS-1:0] pend;
   logic [IDXW-1:0]  pick_idx;
   logic             pick_any;

   dse_flags #(.NREGS(NREGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
      .clr(ctx_switch), .flags(dirty_mask)
   );

   dse_lowbit #(.N(NREGS), .IW(IDXW)) u_pick (
      .vec(pend), .idx(pick_idx), .any(pick_any)
   );

   dse_seq #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_pop(cmd_pop),
      .cmd_sp(cmd_sp), .snap_mask(dirty_mask), .pend(pend),
      .pick_idx(pick_idx), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wb_en(rf_wb_en), .rf_wb_idx(rf_wb_idx), .rf_wb_data(rf_wb_data),
      .busy(busy), .done(done), .sp_out(sp_out)
   );

   logic unused_any;
   assign unused_any = pick_any;
endmodule

// File: rtl/dse_checker.sv
module dse_checker #(
   parameter int NREGS = 32,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int IDXW  = $clog2(NREGS),
   localparam int BYTES = DW / 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rf_we,
   input logic [IDXW-1:0]  rf_waddr,
   input logic             ctx_switch,
   input logic [NREGS-1:0] dirty_mask,
   input logic             busy,
   input logic             done,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ready,
   input logic [AW-1:0]    mem_addr,
   input logic             rf_wb_en
);
   assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> dirty_mask[$past(rf_waddr)]);

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_switch && !rf_we) |=> (dirty_mask == '0));

   assert_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_switch && rf_we) |=> (dirty_mask == (NREGS'(1) << $past(rf_waddr))));

   assert_wb_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wb_en |-> (mem_req && mem_ready && !mem_we));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(BYTES))));
endmodule

bind dirty_save_engine dse_checker #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr),
   .ctx_switch(ctx_switch), .dirty_mask(dirty_mask), .busy(busy), .done(done),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
   .mem_addr(mem_addr), .rf_wb_en(rf_wb_en)
);

// File: tb/sim_dirty_save_engine.sv
`timescale 1ns/1ps
module sim_dirty_save_engine;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        rf_we = 0;
   logic [4:0]  rf_waddr = 0;
   logic        ctx_switch = 0, cmd_push = 0, cmd_pop = 0;
   logic [31:0] cmd_sp = 0;
   logic        busy, done, mem_req, mem_we, mem_ready = 0, rf_wb_en;
   logic [31:0] sp_out, dirty_mask, mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wb_data;
   logic [4:0]  rf_rd_idx, rf_wb_idx;

   logic [31:0] rf_m [32];
   logic [31:0] mem_m [64];
   logic [31:0] cur_base = 0;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   assign rf_rd_data = rf_m[rf_rd_idx];
   assign mem_rdata  = mem_m[6'((mem_addr - cur_base) >> 2)];

   dirty_save_engine u0 (
      .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .ctx_switch(ctx_switch), .cmd_push(cmd_push), .cmd_pop(cmd_pop),
      .cmd_sp(cmd_sp), .busy(busy), .done(done), .sp_out(sp_out),
      .dirty_mask(dirty_mask), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wb_en(rf_wb_en), .rf_wb_idx(rf_wb_idx), .rf_wb_data(rf_wb_data)
   );

   typedef struct packed {
      logic [31:0] mask;
      logic [31:0] base;
      logic [31:0] sp;
      logic [3:0]  ready_pat;
      logic        inject;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{32'h0000_0001, 32'h1000, 32'h1008, 4'hF, 1'b0},
      '{32'h8000_0001, 32'h2000, 32'h200C, 4'h5, 1'b0},
      '{32'h0000_00F0, 32'h3000, 32'h3014, 4'hF, 1'b1},
      '{32'h0000_0000, 32'h4000, 32'h4004, 4'h3, 1'b0},
      '{32'hFFFF_FFFF, 32'h5000, 32'h5084, 4'h6, 1'b0},
      '{32'h1248_0000, 32'h6000, 32'h6014, 4'hE, 1'b1}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int next_bit(input logic [31:0] m, input int after);
      for (int i = after + 1; i < 32; i++) if (m[i]) return i;
      return 32;
   endfunction

   function automatic logic [31:0] regval(input int k, input int i);
      return 32'hC0DE_0000 + 32'(k << 8) + 32'(i);
   endfunction

   task automatic pulse_ctx();
      @(negedge clk); ctx_switch = 1;
      @(negedge clk); ctx_switch = 0;
   endtask

   task automatic write_regs(input logic [31:0] m, input int k);
      for (int i = 0; i < 32; i++) begin
         if (m[i]) begin
            @(negedge clk); rf_we = 1; rf_waddr = 5'(i); rf_m[i] = regval(k, i);
         end
      end
      @(negedge clk); rf_we = 0;
   endtask

   // runs one save (is_push) or restore and checks every beat
   task automatic run_seq(input bit is_push, input bit both, input logic [31:0] base,
                          input logic [31:0] m, input logic [31:0] sp_exp,
                          input logic [3:0] pat, input bit inject);
      int beats = 0;
      int cur = -1;
      bit seen_done = 0;
      bit dir_ok = 1;
      cur_base = base;
      @(negedge clk);
      cmd_push = is_push | both; cmd_pop = !is_push | both; cmd_sp = base;
      @(negedge clk);
      cmd_push = 0; cmd_pop = 0;
      for (int cyc = 0; cyc < 400; cyc++) begin
         mem_ready = pat[cyc % 4];
         cmd_pop = inject && (cyc == 1);
         #1;
         if (done) begin seen_done = 1; break; end
         if (mem_req && mem_ready) begin
            check(mem_addr == base + 32'(4 * beats), "R10 beat address", mem_addr, base + 32'(4 * beats));
            if (mem_we != is_push) dir_ok = 0;
            if (beats == 0) begin
               if (is_push) begin
                  check(mem_wdata == m, "R4 descriptor word", mem_wdata, m);
                  mem_m[0] = mem_wdata;
               end
            end else begin
               cur = next_bit(m, cur);
               if (is_push) begin
                  check(mem_wdata == rf_m[cur], "R5 saved register data", mem_wdata, rf_m[cur]);
                  mem_m[beats] = mem_wdata;
               end else begin
                  check(rf_wb_en && rf_wb_idx == 5'(cur), "R6 write-back index", 32'(rf_wb_idx), 32'(cur));
                  if (rf_wb_en) rf_m[rf_wb_idx] = rf_wb_data;
               end
            end
            beats++;
         end
         @(negedge clk);
      end
      cmd_pop = 0; mem_ready = 0;
      check(dir_ok, "R8 beat direction (push wins / commands ignored while busy)", 32'(dir_ok), 1);
      check(seen_done && sp_out == sp_exp, "R7 final address", sp_out, sp_exp);
      check(beats == 1 + $countones(m), "R7 frame length", 32'(beats), 32'(1 + $countones(m)));
      @(negedge clk); #1;
      check(!done && !busy && !mem_req, "R8 idle after sequence, ignored command not started",
            {29'b0, done, busy, mem_req}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) rf_m[i] = 0;
      for (int i = 0; i < 64; i++) mem_m[i] = 0;
      repeat (3) @(negedge clk);
      #1;
      check(!busy && !done && !mem_req && dirty_mask == 0, "R8 reset state",
            dirty_mask | {28'b0, busy, done, mem_req, 1'b0}, 0);
      rst_n = 1;

      // table walk
      for (int k = 0; k < 6; k++) begin
         pulse_ctx();
         #1 check(dirty_mask == 0, "R2 clear on switch", dirty_mask, 0);
         write_regs(VECS[k].mask, k);
         #1 check(dirty_mask == VECS[k].mask, "R1 flags track writes", dirty_mask, VECS[k].mask);
         run_seq(1, 0, VECS[k].base, VECS[k].mask, VECS[k].sp, VECS[k].ready_pat, VECS[k].inject);
         for (int i = 0; i < 32; i++) rf_m[i] = 32'hDEAD_0000 | 32'(i);
         run_seq(0, 0, VECS[k].base, VECS[k].mask, VECS[k].sp, ~VECS[k].ready_pat | 4'h1, VECS[k].inject);
         begin
            int bad = 0;
            for (int i = 0; i < 32; i++) begin
               logic [31:0] e;
               e = VECS[k].mask[i] ? regval(k, i) : (32'hDEAD_0000 | 32'(i));
               if (rf_m[i] !== e) bad++;
            end
            check(bad == 0, "R6 restored set equals saved set", 32'(bad), 0);
         end
      end

      // R3: write merged with a context switch
      pulse_ctx();
      write_regs(32'h0000_0300, 9);
      @(negedge clk); ctx_switch = 1; rf_we = 1; rf_waddr = 5'd5;
      @(negedge clk); ctx_switch = 0; rf_we = 0;
      #1 check(dirty_mask == 32'h20, "R3 same-cycle write survives clear", dirty_mask, 32'h20);

      // R8: push and pop together -> push wins
      rf_m[5] = 32'h1234_5678;
      run_seq(1, 1, 32'h7000, 32'h20, 32'h7008, 4'hF, 0);
      check(mem_m[1] == 32'h1234_5678, "R5 merged save data", mem_m[1], 32'h1234_5678);

      // R1: flag persists without a switch, accumulates
      @(negedge clk); rf_we = 1; rf_waddr = 5'd31;
      @(negedge clk); rf_we = 0;
      #1 check(dirty_mask == 32'h8000_0020, "R1 flags accumulate", dirty_mask, 32'h8000_0020);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule